// File: doc/BRIEF.md
# Vectored Interrupt Controller with Two-Pulse Acknowledge

This block gathers eight interrupt request lines from I/O devices and raises one interrupt request toward a CPU. Each rising edge on a request line records a pending request. A mask register holds back individual lines, and an in-service register records the interrupts that the CPU has accepted but not yet finished. Line 0 has the highest priority and line 7 the lowest. A pending, unmasked request competes only if its priority is above every interrupt that is already in service, so a higher-priority device can nest on top of one being handled.

The CPU answers the interrupt line with two acknowledge pulses. The first pulse selects the winning request, removes it from the pending set and marks it in service. The second pulse reads the identification number, which is a programmable 5-bit base joined with the 3-bit line index, from the vector output while its drive-enable is high. Software ends handling with an end-of-interrupt pulse, which retires the highest-priority in-service entry. A small write port loads the mask and the vector base.

The acknowledge sequencer has two states. IDLE raises the interrupt line whenever an eligible request exists. The transition TAKE goes from IDLE to SECOND on an acknowledge pulse while a request is eligible. In SECOND the interrupt line is low. The transition DELIVER goes from SECOND back to IDLE on the next acknowledge pulse, and the vector is driven during that pulse. An acknowledge pulse in IDLE with nothing eligible is ignored, and the sequencer stays in IDLE.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While and after reset, no request is pending, nothing is in service, all eight lines are masked (mask = 8'hFF), the vector base is 0, and intr, vec_oe and vec_out are all 0.
- R2: A 0-to-1 change on irq_in[i] sets pending bit i at that clock edge. Holding the line high creates no further request. Masked lines are still recorded. If a new edge and a clearing acknowledge hit the same bit in the same cycle, the bit is set.
- R3: In IDLE, intr is high exactly when some pending bit is unmasked and its index is lower than the index of every in-service bit.
- R4: A write with cfg_we=1 and cfg_sel=0 loads the mask from cfg_wdata, where bit i = 1 masks line i. A write with cfg_sel=1 loads the vector base from cfg_wdata[7:3]. Both take effect at that edge.
- R5: An acknowledge pulse in IDLE with an eligible request picks the lowest eligible index. At that edge it clears the pending bit and sets the in-service bit for that index, and intr stays low until the second pulse has been accepted.
- R6: During the second acknowledge pulse, vec_oe = 1 and vec_out = {base[4:0], index[2:0]}. At all other times vec_oe = 0 and vec_out = 0.
- R7: An eoi pulse clears the lowest-index set bit of the in-service register. It has no effect when nothing is in service.
- R8: A pending request whose index is not lower than the lowest in-service index does not raise intr. A request with a lower index does, and it nests.
- R9: An acknowledge pulse in IDLE with no eligible request changes neither the pending nor the in-service register, and the sequencer stays in IDLE.
- R10: After the second pulse, intr comes back in the next cycle only if an eligible request remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Request lines, rising-edge sensitive |
| inta | input | 1 | Acknowledge pulse from the CPU, one cycle per acknowledge |
| eoi | input | 1 | End-of-interrupt command pulse |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Write target: 0 = mask, 1 = vector base |
| cfg_wdata | input | 8 | Configuration write data |
| intr | output | 1 | Interrupt request to the CPU |
| vec_out | output | 8 | Identification number, valid during the second acknowledge |
| vec_oe | output | 1 | Drive-enable for vec_out |

## Verification
Pending, in-service, mask and sequencer state all change at the clock edge where their stimulus is sampled. intr is decoded from those registers, so it reflects a line edge, a mask write, an acknowledge or an end-of-interrupt one cycle after that stimulus. vec_oe and vec_out respond within the same cycle as the second acknowledge pulse. The bench changes inputs just after a falling edge and compares the outputs one time unit later against a cycle model kept in bench functions. The model is updated once per cycle with the same inputs, so every expectation sits in the cycle its register path dictates.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    // Acknowledge sequencer states
    typedef enum logic {
        ST_IDLE   = 1'b0,  // intr may be raised, waiting for first pulse
        ST_SECOND = 1'b1   // first pulse taken, waiting for vector read
    } ack_state_e;

    // Configuration write targets
    typedef enum logic {
        CFG_MASK = 1'b0,
        CFG_BASE = 1'b1
    } cfg_target_e;

endpackage

// File: rtl/irqv_req_latch.sv
module irqv_req_latch #(
    parameter int N_LINES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_i,
    input  logic [N_LINES-1:0] clr_i,
    output logic [N_LINES-1:0] irr_o
);

    logic [N_LINES-1:0] prev_q;
    logic [N_LINES-1:0] irr_q;
    logic [N_LINES-1:0] rise;

    assign rise = irq_i & ~prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            irr_q  <= '0;
        end else begin
            prev_q <= irq_i;
            // a fresh edge wins over a same-cycle acknowledge clear
            irr_q  <= (irr_q & ~clr_i) | rise;
        end
    end

    assign irr_o = irr_q;

    generate
        for (genvar g = 0; g < N_LINES; g++) begin : g_edge_chk
            p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (irq_i[g] && !prev_q[g]) |=> irr_q[g]);
        end
    endgenerate

endmodule

// File: rtl/irqv_resolver.sv
module irqv_resolver #(
    parameter int N_LINES = 8,
    parameter int IDX_W   = $clog2(N_LINES)
) (
    input  logic [N_LINES-1:0] irr_i,
    input  logic [N_LINES-1:0] imr_i,
    input  logic [N_LINES-1:0] isr_i,
    output logic               valid_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic [N_LINES-1:0] grant_o
);

    localparam logic [N_LINES-1:0] LSB_ONE = {{(N_LINES-1){1'b0}}, 1'b1};

    logic [N_LINES-1:0] isr_low;
    logic [N_LINES-1:0] allow;
    logic [N_LINES-1:0] elig;

    // lowest set in-service bit; everything below it may preempt
    assign isr_low = isr_i & (~isr_i + LSB_ONE);
    assign allow   = (isr_i == '0) ? '1 : (isr_low - LSB_ONE);
    assign elig    = irr_i & ~imr_i & allow;

    assign valid_o = |elig;
    assign grant_o = elig & (~elig + LSB_ONE);

    always_comb begin
        idx_o = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (elig[i]) idx_o = IDX_W'(i);
        end
    end

endmodule

// File: rtl/irqv_service_reg.sv
module irqv_service_reg #(
    parameter int N_LINES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] set_i,
    input  logic               eoi_i,
    output logic [N_LINES-1:0] isr_o
);

    localparam logic [N_LINES-1:0] LSB_ONE = {{(N_LINES-1){1'b0}}, 1'b1};

    logic [N_LINES-1:0] isr_q;
    logic [N_LINES-1:0] retire;

    assign retire = eoi_i ? (isr_q & (~isr_q + LSB_ONE)) : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= (isr_q & ~retire) | set_i;
    end

    assign isr_o = isr_q;

    p_eoi_drops_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && isr_q != '0 && set_i == '0) |=>
            ($countones(isr_q) == $countones($past(isr_q)) - 1));

    p_set_visible_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((isr_q & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/irqv_ack_fsm.sv
module irqv_ack_fsm
    import irqv_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inta_i,
    input  logic             valid_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic             take_o,
    output logic             intr_o,
    output logic             drive_o,
    output logic [IDX_W-1:0] idx_o
);

    ack_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (take_o) idx_q <= idx_i;
        end
    end

    // transitions: TAKE (IDLE->SECOND), DELIVER (SECOND->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (inta_i && valid_i) state_d = ST_SECOND;
            ST_SECOND: if (inta_i)            state_d = ST_IDLE;
            default:                          state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        take_o  = 1'b0;
        intr_o  = 1'b0;
        drive_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                intr_o = valid_i;
                take_o = inta_i && valid_i;
            end
            ST_SECOND: drive_o = inta_i;
            default: ;
        endcase
    end

    assign idx_o = idx_q;

    p_intr_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> (!intr_o && state_q == ST_SECOND));

    p_drive_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        drive_o |=> !drive_o);

    p_drive_returns_r10: assert property (@(posedge clk) disable iff (!rst_n)
        drive_o |=> (state_q == ST_IDLE));

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqv_pkg::*;
#(
    parameter int N_LINES = 8,
    parameter int VEC_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_in,
    input  logic               inta,
    input  logic               eoi,
    input  logic               cfg_we,
    input  logic               cfg_sel,
    input  logic [VEC_W-1:0]   cfg_wdata,
    output logic               intr,
    output logic [VEC_W-1:0]   vec_out,
    output logic               vec_oe
);

    localparam int IDX_W  = $clog2(N_LINES);
    localparam int BASE_W = VEC_W - IDX_W;
    localparam logic [N_LINES-1:0] LSB_ONE = {{(N_LINES-1){1'b0}}, 1'b1};

    logic [N_LINES-1:0] imr_q;
    logic [BASE_W-1:0]  base_q;
    logic [N_LINES-1:0] irr;
    logic [N_LINES-1:0] isr;
    logic [N_LINES-1:0] grant;
    logic [N_LINES-1:0] take_mask;
    logic [IDX_W-1:0]   win_idx;
    logic [IDX_W-1:0]   svc_idx;
    logic               win_valid;
    logic               take;
    logic               drive;

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imr_q  <= '1;
            base_q <= '0;
        end else if (cfg_we) begin
            if (cfg_target_e'(cfg_sel) == CFG_MASK) imr_q  <= cfg_wdata[N_LINES-1:0];
            else                                    base_q <= cfg_wdata[VEC_W-1:IDX_W];
        end
    end

    assign take_mask = take ? grant : '0;

    irqv_req_latch #(.N_LINES(N_LINES)) u_req (
        .clk   (clk),
        .rst_n (rst_n),
        .irq_i (irq_in),
        .clr_i (take_mask),
        .irr_o (irr)
    );

    irqv_resolver #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_res (
        .irr_i   (irr),
        .imr_i   (imr_q),
        .isr_i   (isr),
        .valid_o (win_valid),
        .idx_o   (win_idx),
        .grant_o (grant)
    );

    irqv_service_reg #(.N_LINES(N_LINES)) u_isr (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (take_mask),
        .eoi_i (eoi),
        .isr_o (isr)
    );

    irqv_ack_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .inta_i  (inta),
        .valid_i (win_valid),
        .idx_i   (win_idx),
        .take_o  (take),
        .intr_o  (intr),
        .drive_o (drive),
        .idx_o   (svc_idx)
    );

    assign vec_oe  = drive;
    assign vec_out = drive ? {base_q, svc_idx} : '0;

    p_intr_needs_request_r3: assert property (@(posedge clk) disable iff (!rst_n)
        intr |-> ((irr & ~imr_q) != '0));

    p_grant_ahead_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && isr != '0) |-> (grant < (isr & (~isr + LSB_ONE))));

    p_mask_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == 1'b0) |=> (imr_q == $past(cfg_wdata[N_LINES-1:0])));

    p_oe_not_with_intr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |-> !intr);

endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int RND_CYCLES = 4000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] irq_in;
    logic       inta, eoi, cfg_we, cfg_sel;
    logic [7:0] cfg_wdata;
    logic       intr, vec_oe;
    logic [7:0] vec_out;

    int n_checks = 0;
    int n_fails  = 0;

    // model state
    logic [7:0] m_irr, m_isr, m_imr, m_prev;
    logic [4:0] m_base;
    logic       m_st;
    logic [2:0] m_idx;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vector_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .inta(inta), .eoi(eoi),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .intr(intr), .vec_out(vec_out), .vec_oe(vec_oe)
    );

    function automatic logic [7:0] f_elig(logic [7:0] irr, logic [7:0] imr, logic [7:0] isr);
        logic [7:0] r = 8'h00;
        for (int i = 0; i < 8; i++) begin
            if (isr[i]) break;
            if (irr[i] && !imr[i]) r[i] = 1'b1;
        end
        return r;
    endfunction

    function automatic int f_low(logic [7:0] x);
        for (int i = 0; i < 8; i++) if (x[i]) return i;
        return 8;
    endfunction

    task automatic chk(input string tag, input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s %s got %0h expected %0h at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic cyc(input logic [7:0] irq, input logic a, input logic e,
                       input logic we, input logic sel, input logic [7:0] wd,
                       input string tag);
        logic [7:0] elig, nirr, nisr;
        int w;
        logic take;
        @(negedge clk);
        irq_in = irq; inta = a; eoi = e; cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
        #1;
        elig = f_elig(m_irr, m_imr, m_isr);
        chk(tag, "intr", int'(intr), int'(!m_st && elig != 8'h00));
        chk(tag, "vec_oe", int'(vec_oe), int'(m_st && a));
        chk(tag, "vec_out", int'(vec_out), (m_st && a) ? int'({m_base, m_idx}) : 0);
        // advance model by one edge
        w = f_low(elig);
        take = !m_st && a && elig != 8'h00;
        nirr = m_irr;
        nisr = m_isr;
        if (take) nirr[w] = 1'b0;
        nirr = nirr | (irq & ~m_prev);
        if (e && m_isr != 8'h00) nisr[f_low(m_isr)] = 1'b0;
        if (take) nisr[w] = 1'b1;
        if (take) begin
            m_st = 1'b1; m_idx = 3'(w);
        end else if (m_st && a) begin
            m_st = 1'b0;
        end
        if (we) begin
            if (!sel) m_imr = wd;
            else      m_base = wd[7:3];
        end
        m_irr = nirr; m_isr = nisr; m_prev = irq;
    endtask

    // shorthand: idle cycle with line levels
    task automatic idle(input logic [7:0] irq, input string tag);
        cyc(irq, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [7:0] lv;
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0; irq_in = 8'h00; inta = 1'b0; eoi = 1'b0;
        cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = 8'h00;
        m_irr = 8'h00; m_isr = 8'h00; m_imr = 8'hFF; m_prev = 8'h00;
        m_base = 5'd0; m_st = 1'b0; m_idx = 3'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "intr in reset", int'(intr), 0);
        chk("R1", "vec_oe in reset", int'(vec_oe), 0);
        rst_n = 1'b1;
        idle(8'h00, "R1");

        // masked request is recorded but silent; spurious ack ignored
        idle(8'h08, "R2");
        idle(8'h08, "R3");
        cyc(8'h08, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R9");
        cyc(8'h08, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, "R4");   // unmask all
        cyc(8'h08, 1'b0, 1'b0, 1'b1, 1'b1, 8'hA8, "R4");   // base 0x15
        cyc(8'h08, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R5");   // first ack
        idle(8'h08, "R5");
        cyc(8'h08, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R6");   // vector 0xAB
        chk("R6", "vector value", int'(vec_out), 8'hAB);
        idle(8'h08, "R10");
        cyc(8'h08, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R7");
        idle(8'h08, "R2");                                  // held level: no new request
        chk("R2", "held level no intr", int'(intr), 0);
        cyc(8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R7");    // eoi with empty ISR

        // nesting: line 5 in service, 6 blocked, 2 preempts
        idle(8'h20, "R3");
        cyc(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R5");
        cyc(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R6");
        idle(8'h40, "R8");
        idle(8'h40, "R8");
        chk("R8", "lower line blocked", int'(intr), 0);
        idle(8'h44, "R8");
        idle(8'h44, "R8");
        chk("R8", "higher line nests", int'(intr), 1);
        cyc(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R5");
        cyc(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R6");
        chk("R6", "nested vector", int'(vec_out), 8'hAA);
        cyc(8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R7");    // retires line 2
        idle(8'h00, "R8");
        chk("R8", "line 6 still blocked by 5", int'(intr), 0);
        cyc(8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R7");    // retires line 5
        idle(8'h00, "R10");
        chk("R10", "line 6 raises intr", int'(intr), 1);
        cyc(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R5");
        cyc(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R6");
        cyc(8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R7");

        // simultaneous edges and masking of a pending line
        cyc(8'h12, 1'b0, 1'b0, 1'b1, 1'b0, 8'h02, "R4");    // mask line 1
        idle(8'h12, "R4");
        cyc(8'h12, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R5");    // winner 4
        cyc(8'h12, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R6");
        chk("R6", "masked loser skipped", int'(vec_out), 8'hAC);
        cyc(8'h12, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, "R4");    // unmask line 1
        idle(8'h12, "R10");
        chk("R10", "pending line 1 resurfaces", int'(intr), 1);
        cyc(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R5");
        cyc(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R6");
        cyc(8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R7");

        // constrained random traffic
        lv = 8'h00;
        for (int k = 0; k < RND_CYCLES; k++) begin
            logic a, e, we, sel;
            logic [7:0] wd;
            for (int b = 0; b < 8; b++) if ($urandom_range(0, 9) == 0) lv[b] = ~lv[b];
            a   = ($urandom_range(0, 2) == 0);
            e   = ($urandom_range(0, 5) == 0);
            we  = ($urandom_range(0, 19) == 0);
            sel = $urandom_range(0, 1) == 1;
            wd  = sel ? 8'($urandom) : 8'($urandom_range(0, 3) == 0 ? $urandom : 0);
            cyc(lv, a, e, we, sel, wd, "RND");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule